// File: doc/BRIEF.md
# Extended IO Interrupt Router

This block collects 256 level-sensitive interrupt sources and steers each one to one or more local CPU interrupt lines. Software reaches it over a simple 32-bit register bus with byte strobes. For each vector it can program an enable bit and an 8-bit route byte. It can also read back a status bit that shows each source as sampled, a read-only capability word, and a small configuration word.

A vector reaches a CPU only when four things hold: its enable bit is set, its status bit is set, the global enable bit in the configuration word is set, and its route byte selects that CPU. A configuration bit chooses how the route byte is read. In node/mask mode, the upper nibble names a node and the lower nibble is a core mask inside that node. In direct-index mode, the whole byte is the binary number of the target CPU, so 256 targets can be addressed. Besides the per-CPU request lines, the block drives a per-CPU view of which vectors are currently active for that CPU.

Top module: `eio_router`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, route byte, configuration bit, `bus_rdata` and `cpu_irq` read zero.
- R2: The enable bit for vector v is read/write at address 0x1600 + (v>>5)*4, bit v&31. A byte strobe bit gates its byte.
- R3: The status bit for vector v is read at 0x1800 + (v>>5)*4, bit v&31. It shows `irq_in[v]` as sampled at the previous clock edge. Writes to these words are ignored.
- R4: The route byte for vector v lives at 0x1C00 + (v with bits 1:0 cleared), in bits (v&3)*8 +: 8. Only the lanes whose `bus_be` bit is set are written, so a full-strobe write replaces all four bytes. A read returns the stored bytes exactly.
- R5: The capability word at 0x40000000 reads the FEATURE parameter (default 0xF: bit0 virtualisation, bit1 enable option, bit2 interrupt encode, bit3 direct index). Writes to it are ignored.
- R6: The configuration word at 0x40000004 keeps bits 1 (global enable), 2 (interrupt encode) and 3 (direct index) as read/write. All other bits read 0.
- R7: `cpu_irq[i]` is high exactly when some vector is enabled, has its status bit set, is routed to CPU i, and configuration bit 1 is set. The output follows the clock edge that changes any of these, so clearing an enable drops the request one cycle after the write.
- R8: With configuration bit 3 set, a vector reaches local CPU i only when its route byte equals CPU_BASE + i (default CPU_BASE = 8).
- R9: With configuration bit 3 clear, a vector whose route byte has upper nibble equal to LOCAL_NODE (default 2) reaches every local CPU i (i < 4) whose bit i is set in the lower nibble.
- R10: With configuration bit 3 clear, a route byte whose upper nibble differs from LOCAL_NODE reaches no local CPU.
- R11: `cpu_pend[i*256 + v]` is high exactly when vector v currently drives CPU i under R7.
- R12: A read strobe loads `bus_rdata` at the next edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 32 | Byte address of a 32-bit word |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 256 | Level interrupt sources |
| cpu_irq | output | 4 | Interrupt request per local CPU |
| cpu_pend | output | 1024 | Per-CPU active vectors, index cpu*256+vector |

## Verification
A corrupted enable, route or configuration bit shows up on the very next read of its word. It also reaches `cpu_irq` and `cpu_pend` in the same cycle that the source is pending, because decoding is combinational from the stored state. A wrong lane or address decode shows as a neighbouring byte changing, or as an interrupt on the wrong core, right after the write. A mode decode error shows as a request on a core that a direct index or a foreign node should never reach.

// File: rtl/eio_pkg.sv
// Shared constants for the interrupt router: register map and config bits.
// Assumes 32-bit byte addresses and word-aligned accesses.
package eio_pkg;
    localparam logic [31:0] ENA_BASE  = 32'h0000_1600;
    localparam logic [31:0] STS_BASE  = 32'h0000_1800;
    localparam logic [31:0] RTE_BASE  = 32'h0000_1C00;
    localparam logic [31:0] FEAT_ADDR = 32'h4000_0000;
    localparam logic [31:0] CFG_ADDR  = 32'h4000_0004;

    // Positions of the stored configuration bits inside the config word.
    localparam int CFG_EN_BIT  = 1;
    localparam int CFG_IE_BIT  = 2;
    localparam int CFG_DIR_BIT = 3;
endpackage

// File: rtl/eio_regs.sv
// Register file of the interrupt router: enables, sampled status, route bytes,
// configuration and the registered read port. Assumes NUM_VEC is a multiple of 32.
module eio_regs #(
    parameter int          NUM_VEC = 256,
    parameter logic [31:0] FEATURE = 32'h0000_000F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_VEC-1:0]   irq_in,
    output logic [NUM_VEC-1:0]   en_q,
    output logic [NUM_VEC-1:0]   pend_q,
    output logic [NUM_VEC*8-1:0] rt_q,
    output logic                 cfg_en,
    output logic                 cfg_dir
);
    import eio_pkg::*;

    localparam int EN_WORDS = NUM_VEC / 32;
    localparam int RT_WORDS = NUM_VEC / 4;

    logic [3:1]  cfg_q;
    logic [31:0] rd_mux;

    // Sample the interrupt sources every edge; status needs no reset value.
    always_ff @(posedge clk) begin
        pend_q <= irq_in;
    end

    // Enable bits: byte-strobed writes into the addressed enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (bus_addr == ENA_BASE + 32'((v >> 5) * 4) && bus_be[(v & 31) >> 3])
                    en_q[v] <= bus_wdata[v & 31];
            end
        end
    end

    // Route bytes: each strobed lane of the addressed word replaces one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else if (bus_wr) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (bus_addr == RTE_BASE + 32'(v & ~3) && bus_be[v & 3])
                    rt_q[v*8 +: 8] <= bus_wdata[(v & 3)*8 +: 8];
            end
        end
    end

    // Configuration word: only the three defined bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (bus_wr && bus_addr == CFG_ADDR && bus_be[0])
            cfg_q <= bus_wdata[3:1];
    end

    assign cfg_en  = cfg_q[CFG_EN_BIT];
    assign cfg_dir = cfg_q[CFG_DIR_BIT];

    // Read selection across all mapped words; unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (bus_addr == ENA_BASE + 32'(w * 4)) rd_mux = en_q[w*32 +: 32];
            if (bus_addr == STS_BASE + 32'(w * 4)) rd_mux = pend_q[w*32 +: 32];
        end
        for (int w = 0; w < RT_WORDS; w++) begin
            if (bus_addr == RTE_BASE + 32'(w * 4)) rd_mux = rt_q[w*32 +: 32];
        end
        if (bus_addr == FEAT_ADDR) rd_mux = FEATURE;
        if (bus_addr == CFG_ADDR)  rd_mux = {28'd0, cfg_q, 1'b0};
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    a_r3_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == $past(irq_in));
    a_r4_route_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 4'hF && bus_addr == RTE_BASE) |=> rt_q[31:0] == $past(bus_wdata));
    a_r6_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be[0] && bus_addr == CFG_ADDR) |=> cfg_q == $past(bus_wdata[3:1]));
    a_r5_feature_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == FEAT_ADDR) |=> bus_rdata == FEATURE);
endmodule

// File: rtl/eio_route_dec.sv
// Decodes one route byte into a local-CPU select mask. Direct-index mode compares
// the byte with each CPU's global index; node/mask mode needs a node match and
// uses the low nibble as a core mask. Assumes at most four cores per node.
module eio_route_dec #(
    parameter int         NUM_CPU    = 4,
    parameter logic [3:0] LOCAL_NODE = 4'd2,
    parameter int         CPU_BASE   = 8
) (
    input  logic [7:0]         route,
    input  logic               dir_mode,
    output logic [NUM_CPU-1:0] sel
);
    logic node_hit;
    assign node_hit = (route[7:4] == LOCAL_NODE);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        localparam logic [7:0] GIDX = 8'(CPU_BASE + i);
        if (i < 4) begin : g_mask
            // Core i is reachable by either encoding.
            assign sel[i] = dir_mode ? (route == GIDX) : (node_hit && route[i]);
        end else begin : g_idx
            // Beyond the nibble mask only the direct index can reach core i.
            assign sel[i] = dir_mode && (route == GIDX);
        end
    end

    // Immediate checks on the decode of each mode.
    always_comb begin
        if (dir_mode) begin
            a_r8_single_target: assert ($onehot0(sel));
        end
        if (!dir_mode && !node_hit) begin
            a_r10_foreign_node: assert (sel == '0);
        end
    end
endmodule

// File: rtl/eio_router.sv
// Top of the interrupt router: register file, one route decoder per vector and
// the per-CPU request merge. Outputs are combinational from registered state.
module eio_router #(
    parameter int          NUM_VEC    = 256,
    parameter int          NUM_CPU    = 4,
    parameter logic [3:0]  LOCAL_NODE = 4'd2,
    parameter int          CPU_BASE   = 8,
    parameter logic [31:0] FEATURE    = 32'h0000_000F
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [31:0]                bus_addr,
    input  logic [3:0]                 bus_be,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_VEC-1:0]         irq_in,
    output logic [NUM_CPU-1:0]         cpu_irq,
    output logic [NUM_CPU*NUM_VEC-1:0] cpu_pend
);
    logic [NUM_VEC-1:0]   en_q, pend_q, act;
    logic [NUM_VEC*8-1:0] rt_q;
    logic                 cfg_en, cfg_dir;

    eio_regs #(.NUM_VEC(NUM_VEC), .FEATURE(FEATURE)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .en_q(en_q), .pend_q(pend_q),
        .rt_q(rt_q), .cfg_en(cfg_en), .cfg_dir(cfg_dir)
    );

    // A vector is live when enabled, pending and the block is globally on.
    assign act = en_q & pend_q & {NUM_VEC{cfg_en}};

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [NUM_CPU-1:0] sel;
        eio_route_dec #(.NUM_CPU(NUM_CPU), .LOCAL_NODE(LOCAL_NODE), .CPU_BASE(CPU_BASE)) u_dec (
            .route(rt_q[v*8 +: 8]), .dir_mode(cfg_dir), .sel(sel)
        );
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_pend
            assign cpu_pend[c*NUM_VEC + v] = act[v] & sel[c];
        end
    end

    // Merge the per-CPU views into one request line per CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        assign cpu_irq[c] = |cpu_pend[c*NUM_VEC +: NUM_VEC];
    end

    a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> cpu_irq == '0);
    a_r7_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> ((en_q & pend_q) != '0));
endmodule

// File: tb/eio_router_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module eio_router_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]  bus_addr = '0, bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] irq_in = '0;
    logic [3:0]   cpu_irq;
    logic [1023:0] cpu_pend;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    eio_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_irq(cpu_irq), .cpu_pend(cpu_pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic src(input int v, input logic lvl);
        @(negedge clk);
        irq_in[v] = lvl;
        @(negedge clk);
    endtask

    // Monitor: a read strobe seen at an edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
        rd(32'h1600, 32'h0, "R1 enable word reset");
        rd(32'h1C04, 32'h0, "R1 route word reset");
        rd(32'h4000_0004, 32'h0, "R1 config reset");
        rd(32'h4000_0000, 32'hF, "R5 feature value");
        // R2 enables
        wr(32'h1600, 32'hFFFF_FFFF, 4'hF);
        rd(32'h1600, 32'hFFFF_FFFF, "R2 enable word 0");
        wr(32'h161C, 32'h8000_0000, 4'hF);
        rd(32'h161C, 32'h8000_0000, "R2 enable vector 255");
        // R4 route lanes
        wr(32'h1C04, 32'h4433_2211, 4'hF);
        rd(32'h1C04, 32'h4433_2211, "R4 full route write");
        wr(32'h1C04, 32'hAABB_CCDD, 4'b0010);
        rd(32'h1C04, 32'h4433_CC11, "R4 single lane write");
        // R6 config, R5 feature read-only
        wr(32'h4000_0004, 32'hFFFF_FFFF, 4'hF);
        rd(32'h4000_0004, 32'h0000_000E, "R6 config bits");
        wr(32'h4000_0000, 32'h0, 4'hF);
        rd(32'h4000_0000, 32'hF, "R5 feature ignores write");
        // Node/mask mode, vector 5 to node 2 core 2
        wr(32'h4000_0004, 32'h2, 4'hF);
        wr(32'h1C04, 32'h0000_2400, 4'b0010);
        src(5, 1'b1);
        src(40, 1'b1);
        rd(32'h1800, 32'h20, "R3 status word 0");
        rd(32'h1804, 32'h100, "R3 status word 1");
        wr(32'h1800, 32'h0, 4'hF);
        rd(32'h1800, 32'h20, "R3 status ignores write");
        chk("R9 node match core 2", 32'(cpu_irq), 32'h4);
        chk("R11 pend view cpu2 v5", 32'(cpu_pend[517]), 32'h1);
        chk("R11 pend view cpu0 v5", 32'(cpu_pend[5]), 32'h0);
        wr(32'h1C04, 32'h0000_2B00, 4'b0010);
        chk("R9 multi-core mask", 32'(cpu_irq), 32'hB);
        wr(32'h1C04, 32'h0000_1F00, 4'b0010);
        chk("R10 foreign node", 32'(cpu_irq), 32'h0);
        // R7 global enable
        wr(32'h1C04, 32'h0000_2400, 4'b0010);
        wr(32'h4000_0004, 32'h0, 4'hF);
        chk("R7 global enable off", 32'(cpu_irq), 32'h0);
        wr(32'h4000_0004, 32'h2, 4'hF);
        chk("R7 global enable on", 32'(cpu_irq), 32'h4);
        // R8 direct index mode
        wr(32'h4000_0004, 32'hA, 4'hF);
        chk("R8 mask byte ignored", 32'(cpu_irq), 32'h0);
        wr(32'h1C04, 32'h0000_0A00, 4'b0010);
        chk("R8 index 10 core 2", 32'(cpu_irq), 32'h4);
        wr(32'h1C04, 32'h0000_0900, 4'b0010);
        chk("R8 index 9 core 1", 32'(cpu_irq), 32'h2);
        wr(32'h1600, 32'hFFFF_FFDF, 4'hF);
        chk("R7 enable clear drops request", 32'(cpu_irq), 32'h0);
        // Last vector, top lane
        src(255, 1'b1);
        wr(32'h1CFC, 32'h0B00_0000, 4'b1000);
        chk("R8 vector 255 core 3", 32'(cpu_irq), 32'h8);
        chk("R11 pend view cpu3 v255", 32'(cpu_pend[1023]), 32'h1);
        rd(32'h1CFC, 32'h0B00_0000, "R4 top lane readback");
        rd(32'h1000, 32'h0, "R12 unmapped read");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule